// File: doc/BRIEF.md
# Sequential Page Advance Remapper

A block transfer engine walks a virtual address one word at a time. When the walk leaves a 256-word page, the real address it holds no longer applies. This block finds the real address that replaces it. It moves the virtual page/word value one page forward or one page back. A carry or borrow from that step goes into the virtual segment byte. The block then looks up the new virtual page in an external page map. The result is a new real address: the real page from the map entry, combined with the word-within-page offset that the transfer was already on.

The stream kind decides how the usage flags in the map entry are maintained. A read stream sets the referenced flag if the entry does not already have it. A write stream sets both the referenced and dirty flags unless the entry is already dirty. A write stream that finds a write-protected or absent entry leaves through an abort pulse instead of completing. The updated virtual value and segment come back on the outputs, so the caller can feed them into the next page crossing.

The map port uses a request/acknowledge handshake. The block holds its request until it is acknowledged, for the lookup and for any write-back. It then pulses `done` for one cycle.

Top module: `pgadv_remap`

## Requirements
- R1: With `step_back`=0, the virtual page field (bits 15:8 of `virt_in`) increases by 1 and the word bits 7:0 pass through unchanged. If the page was 0xFF it wraps to 0x00 and the virtual segment increases by 1; otherwise the segment is unchanged.
- R2: With `step_back`=1, the virtual page field decreases by 1. If the page was 0x00 it wraps to 0xFF and the virtual segment decreases by 1; otherwise the segment is unchanged.
- R3: A map entry is 24 bits: real segment in bits 23:16, real page in bits 15:8, flags in bits 7:0. On completion, `real_addr` = {entry real page, `old_word`} and `real_seg` = entry real segment. The entry used is the one after any write-back; the write-back touches only flag bits.
- R4: On completion, `virt_out` and `vseg_out` hold the stepped virtual value and segment. The lookup goes to map page {stepped segment, stepped page}.
- R5: Read stream (`dst_stream`=0). If flag bit 4 (referenced) is clear, the entry is written back with 0x10 ORed in. If bit 4 is set, nothing is written. Flag bits 6 and 7 are not examined on a read stream.
- R6: Write stream (`dst_stream`=1) with flag bits 7 and 6 both clear. If flag bit 5 (dirty) is clear, the entry is written back with 0x30 ORed in. If bit 5 is set, nothing is written.
- R7: Write stream whose entry has flag bit 6 (write protect) or bit 7 (absent) set: `abort` pulses for one cycle. `done` stays low, nothing is written, and all four result outputs keep their previous values.
- R8: `map_req`, `map_we`, `map_page` and `map_wdata` stay steady until `map_ack` is seen. `done` rises in the cycle after the final acknowledge and lasts exactly one cycle.
- R9: A `start` pulse while an operation is in flight is ignored and causes no extra result.
- R10: Synchronous active-high reset clears `done`, `abort`, `map_req` and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a page advance (ignored while busy) |
| step_back | input | 1 | 1 = step one page backward, 0 = forward |
| dst_stream | input | 1 | 1 = write (destination) stream, 0 = read stream |
| virt_in | input | 16 | Current virtual page/word value |
| vseg_in | input | 8 | Current virtual segment byte |
| old_word | input | 8 | Word-within-page offset of the current real address |
| map_req | output | 1 | Map access request |
| map_we | output | 1 | 1 = entry write-back, 0 = lookup |
| map_page | output | 16 | Virtual page number {segment, page} |
| map_wdata | output | 24 | Entry to write back |
| map_ack | input | 1 | Map access acknowledge |
| map_rdata | input | 24 | Entry returned by the lookup (valid with ack) |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | One-cycle abnormal-exit pulse (write stream only) |
| real_addr | output | 16 | New real address |
| real_seg | output | 8 | New real segment |
| virt_out | output | 16 | Stepped virtual value for the next crossing |
| vseg_out | output | 8 | Stepped virtual segment |

## Verification
The bench steps pages forward and backward. It uses mid-segment pages, so that forward and backward errors in the page arithmetic show up, and the 0xFF and 0x00 pages, which show whether carry and borrow reach the segment byte. Flag patterns are chosen per stream. Clear and set referenced bits on read entries show whether write-back is conditional. Clean, dirty, write-protected and absent entries on the write stream separate the 0x30 update, the skip and the abort. One read-stream entry carries the protect and absent bits, which shows that a read stream ignores them. The map latency is varied and results are chained through `virt_out`. A second `start` during a stall shows whether a busy request is dropped.

// File: rtl/pgadv_pkg.sv
package pgadv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WBACK} pgadv_st_t;
  localparam int REF_BIT   = 4;
  localparam int DIRTY_BIT = 5;
  localparam int WP_BIT    = 6;
  localparam int ABS_BIT   = 7;
endpackage

// File: rtl/pgadv_step.sv
module pgadv_step #(
  parameter int VW = 16,
  parameter int PB = 8,
  parameter int SW = 8
) (
  input  logic          back,
  input  logic [VW-1:0] virt,
  input  logic [SW-1:0] seg,
  output logic [VW-1:0] virt_n,
  output logic [SW-1:0] seg_n
);
  localparam int PW = VW - PB;
  logic [PW:0] page_ext;

  always_comb begin
    if (back) page_ext = {1'b0, virt[VW-1:PB]} - {{PW{1'b0}}, 1'b1};
    else      page_ext = {1'b0, virt[VW-1:PB]} + {{PW{1'b0}}, 1'b1};
    virt_n = {page_ext[PW-1:0], virt[PB-1:0]};
    if (!page_ext[PW])  seg_n = seg;
    else if (back)      seg_n = seg - {{(SW-1){1'b0}}, 1'b1};
    else                seg_n = seg + {{(SW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/pgadv_policy.sv
module pgadv_policy (
  input  logic       is_dst,
  input  logic [3:0] flg,     // {absent, wprot, dirty, ref}
  output logic       need_wb,
  output logic       fault,
  output logic [1:0] set_bits // {dirty, ref}
);
  always_comb begin
    if (is_dst) begin
      fault    = flg[3] | flg[2];
      need_wb  = !fault && !flg[1];
      set_bits = 2'b11;
    end else begin
      fault    = 1'b0;
      need_wb  = !flg[0];
      set_bits = 2'b01;
    end
  end
endmodule

// File: rtl/pgadv_remap.sv
module pgadv_remap
  import pgadv_pkg::*;
#(
  parameter int VW  = 16,
  parameter int PB  = 8,
  parameter int SW  = 8,
  parameter int RPW = 8,
  parameter int RSW = 8,
  parameter int FW  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 step_back,
  input  logic                 dst_stream,
  input  logic [VW-1:0]        virt_in,
  input  logic [SW-1:0]        vseg_in,
  input  logic [PB-1:0]        old_word,
  output logic                 map_req,
  output logic                 map_we,
  output logic [SW+VW-PB-1:0]  map_page,
  output logic [RSW+RPW+FW-1:0] map_wdata,
  input  logic                 map_ack,
  input  logic [RSW+RPW+FW-1:0] map_rdata,
  output logic                 done,
  output logic                 abort,
  output logic [RPW+PB-1:0]    real_addr,
  output logic [RSW-1:0]       real_seg,
  output logic [VW-1:0]        virt_out,
  output logic [SW-1:0]        vseg_out
);
  localparam int EW = RSW + RPW + FW;

  pgadv_st_t     state;
  logic [VW-1:0] virt_r, virt_n;
  logic [SW-1:0] seg_r, seg_n;
  logic [PB-1:0] off_r;
  logic          dst_r;
  logic [EW-1:0] entry_r, fin_entry, wb_entry;
  logic          pol_wb, pol_fault;
  logic [1:0]    pol_set;
  logic [FW-1:0] set_mask;

  pgadv_step #(.VW(VW), .PB(PB), .SW(SW)) u_step (
    .back(step_back), .virt(virt_in), .seg(vseg_in),
    .virt_n(virt_n), .seg_n(seg_n)
  );

  pgadv_policy u_pol (
    .is_dst(dst_r), .flg(map_rdata[ABS_BIT:REF_BIT]),
    .need_wb(pol_wb), .fault(pol_fault), .set_bits(pol_set)
  );

  always_comb begin
    set_mask            = '0;
    set_mask[REF_BIT]   = pol_set[0];
    set_mask[DIRTY_BIT] = pol_set[1];
    wb_entry  = map_rdata | {{(EW-FW){1'b0}}, set_mask};
    fin_entry = (state == ST_WBACK) ? entry_r : map_rdata;
  end

  assign map_req   = (state != ST_IDLE);
  assign map_we    = (state == ST_WBACK);
  assign map_page  = {seg_r, virt_r[VW-1:PB]};
  assign map_wdata = entry_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      virt_r    <= '0;
      seg_r     <= '0;
      off_r     <= '0;
      dst_r     <= 1'b0;
      entry_r   <= '0;
      done      <= 1'b0;
      abort     <= 1'b0;
      real_addr <= '0;
      real_seg  <= '0;
      virt_out  <= '0;
      vseg_out  <= '0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          virt_r <= virt_n;
          seg_r  <= seg_n;
          off_r  <= old_word;
          dst_r  <= dst_stream;
          state  <= ST_READ;
        end
        ST_READ: if (map_ack) begin
          if (pol_fault) begin
            abort <= 1'b1;
            state <= ST_IDLE;
          end else if (pol_wb) begin
            entry_r <= wb_entry;
            state   <= ST_WBACK;
          end else begin
            done      <= 1'b1;
            real_addr <= {fin_entry[FW+RPW-1:FW], off_r};
            real_seg  <= fin_entry[EW-1:EW-RSW];
            virt_out  <= virt_r;
            vseg_out  <= seg_r;
            state     <= ST_IDLE;
          end
        end
        ST_WBACK: if (map_ack) begin
          done      <= 1'b1;
          real_addr <= {fin_entry[FW+RPW-1:FW], off_r};
          real_seg  <= fin_entry[EW-1:EW-RSW];
          virt_out  <= virt_r;
          vseg_out  <= seg_r;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgadv_remap_chk.sv
module pgadv_remap_chk
  import pgadv_pkg::*;
#(
  parameter int MPW = 16,
  parameter int EW  = 24
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic           abort,
  input logic           map_req,
  input logic           map_we,
  input logic           map_ack,
  input logic [MPW-1:0] map_page,
  input logic [EW-1:0]  map_wdata
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (map_req && !map_ack) |=> (map_req && $stable(map_page) && $stable(map_we) && $stable(map_wdata)));
  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(map_ack));
  assert_idle_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    (done || abort) |-> !map_req);
  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && abort));
  assert_abort_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    abort |-> !$past(map_we));
  assert_wb_ref_R5: assert property (@(posedge clk) disable iff (rst)
    (map_req && map_we) |-> map_wdata[REF_BIT]);
endmodule

bind pgadv_remap pgadv_remap_chk #(.MPW(SW+VW-PB), .EW(RSW+RPW+FW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .abort(abort), .map_req(map_req),
  .map_we(map_we), .map_ack(map_ack), .map_page(map_page), .map_wdata(map_wdata)
);

// File: tb/pgadv_remap_bench.sv
module pgadv_remap_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, step_back = 1'b0, dst_stream = 1'b0;
  logic [15:0] virt_in = '0;
  logic [7:0]  vseg_in = '0, old_word = '0;
  logic        map_req, map_we, map_ack = 1'b0;
  logic [15:0] map_page;
  logic [23:0] map_wdata, map_rdata = '0;
  logic        done, abort;
  logic [15:0] real_addr, virt_out;
  logic [7:0]  real_seg, vseg_out;

  always #5 clk = ~clk;

  pgadv_remap u_pgadv_remap (
    .clk(clk), .rst(rst), .start(start), .step_back(step_back),
    .dst_stream(dst_stream), .virt_in(virt_in), .vseg_in(vseg_in),
    .old_word(old_word), .map_req(map_req), .map_we(map_we),
    .map_page(map_page), .map_wdata(map_wdata), .map_ack(map_ack),
    .map_rdata(map_rdata), .done(done), .abort(abort),
    .real_addr(real_addr), .real_seg(real_seg), .virt_out(virt_out),
    .vseg_out(vseg_out)
  );

  typedef struct {
    logic        ab;
    logic [15:0] ra;
    logic [7:0]  rs;
    logic [15:0] vo;
    logic [7:0]  so;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, fails = 0, served = 0, writes = 0, lat = 0, cnt = 0;
  logic [23:0] mem [int];
  logic [15:0] last_ra = '0, last_vo = '0;
  logic [7:0]  last_rs = '0, last_so = '0;

  // map model
  always @(negedge clk) begin
    if (map_ack) begin
      map_ack = 1'b0;
      cnt = 0;
    end else if (map_req && !rst) begin
      if (cnt >= lat) begin
        map_ack = 1'b1;
        if (map_we) begin
          mem[int'(map_page)] = map_wdata;
          writes++;
        end else map_rdata = mem[int'(map_page)];
      end else cnt++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && (done || abort)) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected result: done=%0b abort=%0b expected none", done, abort);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (abort !== e.ab || done !== !e.ab || real_addr !== e.ra || real_seg !== e.rs ||
            virt_out !== e.vo || vseg_out !== e.so) begin
          fails++;
          $display("FAIL %s: got ab=%0b ra=%h rs=%h vo=%h so=%h expected ab=%0b ra=%h rs=%h vo=%h so=%h",
                   e.tag, abort, real_addr, real_seg, virt_out, vseg_out,
                   e.ab, e.ra, e.rs, e.vo, e.so);
        end
      end
      served++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic run_op(input bit back, input bit dst, input logic [15:0] v,
                        input logic [7:0] s, input logic [7:0] w, input logic [23:0] ent,
                        input int latency, input bit extra_start, input string tag);
    logic [7:0]  np, ns;
    logic [23:0] fin;
    bit          wb, ab;
    int          key, w0, s0;
    exp_t        e;
    np = back ? v[15:8] - 8'd1 : v[15:8] + 8'd1;
    if (!back && v[15:8] == 8'hFF)      ns = s + 8'd1;
    else if (back && v[15:8] == 8'h00)  ns = s - 8'd1;
    else                                ns = s;
    ab = dst && (ent[7] || ent[6]);
    wb = !ab && (dst ? !ent[5] : !ent[4]);
    fin = wb ? (ent | (dst ? 24'h30 : 24'h10)) : ent;
    key = int'({ns, np});
    mem[key] = ent;
    lat = latency;
    e.ab = ab;
    e.tag = tag;
    if (ab) begin
      e.ra = last_ra; e.rs = last_rs; e.vo = last_vo; e.so = last_so;
    end else begin
      e.ra = {fin[15:8], w}; e.rs = fin[23:16]; e.vo = {np, v[7:0]}; e.so = ns;
      last_ra = e.ra; last_rs = e.rs; last_vo = e.vo; last_so = e.so;
    end
    sb.push_back(e);
    w0 = writes;
    s0 = served;
    @(negedge clk);
    step_back = back; dst_stream = dst; virt_in = v; vseg_in = s; old_word = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      @(negedge clk);
      step_back = ~back; virt_in = ~v; vseg_in = ~s; old_word = ~w; dst_stream = ~dst;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (served == s0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(mem[key] === fin, {tag, " map entry"}, {8'h0, mem[key]}, {8'h0, fin});
    chk((writes - w0) == (wb ? 1 : 0), {tag, " write count"}, writes - w0, wb ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !abort && !map_req, "R10 reset controls", {29'h0, done, abort, map_req}, 0);
    chk(real_addr == 0 && real_seg == 0 && virt_out == 0 && vseg_out == 0,
        "R10 reset outputs", {real_addr, virt_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    run_op(0, 0, 16'h3A17, 8'h05, 8'h17, 24'h42_9C_00, 0, 0, "R1 R3 R5 fwd read ref clear");
    run_op(0, 0, 16'hFF20, 8'h05, 8'h20, 24'h11_22_10, 1, 0, "R1 R5 fwd carry read ref set");
    run_op(1, 1, 16'h8044, 8'h09, 8'h44, 24'h07_E1_10, 0, 0, "R2 R6 back write clean");
    run_op(1, 1, 16'h00C3, 8'h09, 8'hC3, 24'h33_5A_30, 2, 0, "R2 R6 back borrow write dirty");
    run_op(0, 1, 16'h1200, 8'h01, 8'h00, 24'h66_77_50, 0, 0, "R7 write protect abort");
    run_op(1, 1, 16'h1200, 8'h01, 8'h01, 24'h66_78_80, 1, 0, "R7 absent abort");
    run_op(0, 0, 16'h5501, 8'h02, 8'h01, 24'h0A_B0_D0, 0, 0, "R5 read ignores protect bits");
    run_op(0, 0, last_vo, last_so, 8'h99, 24'h12_34_00, 3, 0, "R4 R8 chained slow map");
    run_op(1, 1, last_vo, last_so, 8'h3E, 24'h0F_F0_00, 3, 1, "R9 R8 start while busy");
    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R9 queue drained", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule